// File: doc/BRIEF.md
# Iterative Single/Triple DES Cipher Core

This core turns one 64-bit word into its DES image, either forward (encrypt) or inverse (decrypt), under one key or under a three-key triple-DES sequence. It uses the standard initial and final permutations, the expansion, the eight substitution boxes, the P permutation and the two-choice key schedule. The rounds are computed iteratively by a small datapath that reuses one round unit (or two chained round units when the build parameter asks for two rounds per clock).

A host sets the three keys, the direction, the single/triple select and the data word, then pulses `start` while the core is idle. The core copies every operand on that edge, so the inputs may change afterwards. Each DES stage spends one cycle loading its permuted data and key, then 16/`ROUNDS_PER_CLK` cycles of rounds. Triple-DES runs three such stages back to back. The current stage number is visible on `stage`. The result appears on `data_out` together with a one-cycle `done` pulse and stays there until the next result.

Bit 1 of the standard's left-to-right numbering is bit 63 of every 64-bit port, and bit 64 is bit 0.

Top module: `tdes_iter_core`

## Requirements
- R1: With `triple`=0 and `encrypt`=1, `data_out` is the DES encryption of `data_in` under `key0`, with standard bit 1 at vector bit 63 (key 133457799BBCDFF1 maps 0123456789ABCDEF to 85E813540F0AB405).
- R2: With `encrypt`=0 the core applies the sixteen subkeys in reverse order, so a single-DES decryption under the same key returns the original plaintext.
- R3: Triple-DES encryption equals encrypt(`key0`), then decrypt(`key1`), then encrypt(`key2`). Triple-DES decryption equals decrypt(`key2`), then encrypt(`key1`), then decrypt(`key0`).
- R4: `done` rises exactly P cycles after the edge that accepts `start` for single DES, and 3P cycles after it for triple DES, where P = 1 + 16/`ROUNDS_PER_CLK` (17 or 9).
- R5: `stage` reads 0 when idle. It reads 1, 2 or 3 for the stage running, and it rises by one at each stage boundary. Single DES shows only stage 1.
- R6: `done` is high for exactly one cycle, in the cycle where `stage` has returned to 0. `data_out` changes only in that cycle and holds its value until the next result.
- R7: A `start` pulse while `stage` is not 0 is ignored. It does not restart, lengthen or alter the running operation.
- R8: Keys, data, direction and mode are captured on the accepting edge. Later changes to those inputs do not affect the running result.
- R9: After reset, `stage` is 0, `done` is 0 and `data_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation when idle |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt |
| triple | input | 1 | 1 = triple DES, 0 = single DES |
| key0 | input | 64 | Single-DES key; first encrypt key of triple DES |
| key1 | input | 64 | Middle key of triple DES |
| key2 | input | 64 | Last encrypt key of triple DES |
| data_in | input | 64 | Word to transform |
| data_out | output | 64 | Result, held until the next result |
| done | output | 1 | One-cycle pulse when a result is written |
| stage | output | 2 | 0 idle, otherwise the running stage 1 to 3 |

## Verification
The assertions assume that `start` is a synchronous input, and that it is driven only after the internal reset release, which takes two clocks after `rst_n` rises. They also assume that operands are meaningful only on the accepting edge. The stimulus waits several cycles after reset before its first pulse. It drives every input on the falling clock edge. It deliberately pulses `start` mid-operation and changes the data and key after acceptance, to show that such traffic is ignored. Correctness of the cipher itself is anchored on known-answer words and on compositions of single-DES runs, so it does not depend on any model of the rounds.

// File: rtl/tdes_iter_pkg.sv
package tdes_iter_pkg;

  localparam int N_ROUNDS = 16;
  localparam int IDX_W    = 4;

  localparam int IP_T [64] = '{
    58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
    62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
    57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
    61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

  localparam int FP_T [64] = '{
    40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
    38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
    36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
    34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};

  localparam int E_T [48] = '{
    32,1,2,3,4,5,     4,5,6,7,8,9,     8,9,10,11,12,13,
    12,13,14,15,16,17, 16,17,18,19,20,21, 20,21,22,23,24,25,
    24,25,26,27,28,29, 28,29,30,31,32,1};

  localparam int P_T [32] = '{
    16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
    2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

  localparam int PC1_T [56] = '{
    57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
    10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
    63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
    14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

  localparam int PC2_T [48] = '{
    14,17,11,24,1,5,   3,28,15,6,21,10,  23,19,12,4,26,8,
    16,7,27,20,13,2,   41,52,31,37,47,55, 30,40,51,45,33,48,
    44,49,39,56,34,53, 46,42,50,36,29,32};

  localparam int S1_T [64] = '{
    14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
    0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
    4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
    15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
  localparam int S2_T [64] = '{
    15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
    3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
    0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
    13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
  localparam int S3_T [64] = '{
    10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
    13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
    13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
    1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
  localparam int S4_T [64] = '{
    7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
    13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
    10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
    3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
  localparam int S5_T [64] = '{
    2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
    14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
    4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
    11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
  localparam int S6_T [64] = '{
    12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
    10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
    9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
    4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
  localparam int S7_T [64] = '{
    4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
    13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
    1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
    6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
  localparam int S8_T [64] = '{
    13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
    1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
    7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
    2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

  // Tables number bits 1..N from the left; vector bit = width - number.
  function automatic logic [63:0] perm_ip(input logic [63:0] x);
    logic [63:0] y;
    for (int j = 0; j < 64; j++) y[63-j] = x[64-IP_T[j]];
    return y;
  endfunction

  function automatic logic [63:0] perm_fp(input logic [63:0] x);
    logic [63:0] y;
    for (int j = 0; j < 64; j++) y[63-j] = x[64-FP_T[j]];
    return y;
  endfunction

  function automatic logic [47:0] perm_e(input logic [31:0] x);
    logic [47:0] y;
    for (int j = 0; j < 48; j++) y[47-j] = x[32-E_T[j]];
    return y;
  endfunction

  function automatic logic [31:0] perm_p(input logic [31:0] x);
    logic [31:0] y;
    for (int j = 0; j < 32; j++) y[31-j] = x[32-P_T[j]];
    return y;
  endfunction

  function automatic logic [55:0] perm_pc1(input logic [63:0] x);
    logic [55:0] y;
    for (int j = 0; j < 56; j++) y[55-j] = x[64-PC1_T[j]];
    return y;
  endfunction

  function automatic logic [47:0] perm_pc2(input logic [55:0] x);
    logic [47:0] y;
    for (int j = 0; j < 48; j++) y[47-j] = x[56-PC2_T[j]];
    return y;
  endfunction

  function automatic logic [3:0] sbox(input int n, input logic [5:0] b);
    logic [5:0] a;
    a = {b[5], b[0], b[4:1]};
    case (n)
      0:       return 4'(S1_T[a]);
      1:       return 4'(S2_T[a]);
      2:       return 4'(S3_T[a]);
      3:       return 4'(S4_T[a]);
      4:       return 4'(S5_T[a]);
      5:       return 4'(S6_T[a]);
      6:       return 4'(S7_T[a]);
      default: return 4'(S8_T[a]);
    endcase
  endfunction

  // Total left rotation of C and D before the subkey of round idx+1.
  function automatic int cum_shift(input logic [IDX_W-1:0] idx);
    int s;
    s = 0;
    for (int j = 0; j < N_ROUNDS; j++)
      if (j <= int'(idx)) s += (j == 0 || j == 1 || j == 8 || j == 15) ? 1 : 2;
    return s;
  endfunction

  function automatic logic [27:0] rotl28(input logic [27:0] x, input int s);
    logic [55:0] t;
    t = {x, x} << s;
    return t[55:28];
  endfunction

endpackage

// File: rtl/tdes_iter_subkey.sv
module tdes_iter_subkey
  import tdes_iter_pkg::*;
(
  input  logic [55:0]      cd,
  input  logic [IDX_W-1:0] idx,
  output logic [47:0]      subkey
);
  logic [27:0] c_rot;
  logic [27:0] d_rot;

  always_comb begin
    c_rot  = rotl28(cd[55:28], cum_shift(idx));
    d_rot  = rotl28(cd[27:0],  cum_shift(idx));
    subkey = perm_pc2({c_rot, d_rot});
  end
endmodule

// File: rtl/tdes_iter_round.sv
module tdes_iter_round
  import tdes_iter_pkg::*;
(
  input  logic [63:0] lr_in,
  input  logic [47:0] subkey,
  output logic [63:0] lr_out
);
  logic [47:0] mixed;
  logic [31:0] sub_out;

  always_comb begin
    mixed = perm_e(lr_in[31:0]) ^ subkey;
    for (int i = 0; i < 8; i++)
      sub_out[31-4*i -: 4] = sbox(i, mixed[47-6*i -: 6]);
    lr_out = {lr_in[31:0], lr_in[63:32] ^ perm_p(sub_out)};
  end
endmodule

// File: rtl/tdes_iter_seq.sv
module tdes_iter_seq
  import tdes_iter_pkg::*;
#(
  parameter int STEPS = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             triple,
  output logic [1:0]       stage,
  output logic             loading,
  output logic [IDX_W-1:0] step,
  output logic             tri_mode,
  output logic             accept,
  output logic             last_rnd,
  output logic             fin
);
  logic [1:0]       stage_q, stage_n;
  logic             load_q,  load_n;
  logic [IDX_W-1:0] step_q,  step_n;
  logic             tri_q,   tri_n;

  assign accept   = start && (stage_q == 2'd0);
  assign last_rnd = (stage_q != 2'd0) && !load_q && (step_q == IDX_W'(STEPS - 1));
  assign fin      = last_rnd && (!tri_q || stage_q == 2'd3);
  assign stage    = stage_q;
  assign loading  = load_q;
  assign step     = step_q;
  assign tri_mode = tri_q;

  always_comb begin
    stage_n = stage_q;
    load_n  = load_q;
    step_n  = step_q;
    tri_n   = tri_q;
    if (accept) begin
      stage_n = 2'd1;
      load_n  = 1'b1;
      step_n  = '0;
      tri_n   = triple;
    end else if (stage_q != 2'd0) begin
      if (load_q) begin
        load_n = 1'b0;
        step_n = '0;
      end else if (last_rnd) begin
        if (fin) begin
          stage_n = 2'd0;
          load_n  = 1'b0;
        end else begin
          stage_n = stage_q + 2'd1;
          load_n  = 1'b1;
        end
      end else begin
        step_n = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'd0;
      load_q  <= 1'b0;
      step_q  <= '0;
      tri_q   <= 1'b0;
    end else begin
      stage_q <= stage_n;
      load_q  <= load_n;
      step_q  <= step_n;
      tri_q   <= tri_n;
    end
  end
endmodule

// File: rtl/tdes_iter_core.sv
module tdes_iter_core
  import tdes_iter_pkg::*;
#(
  parameter int ROUNDS_PER_CLK = 1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        encrypt,
  input  logic        triple,
  input  logic [63:0] key0,
  input  logic [63:0] key1,
  input  logic [63:0] key2,
  input  logic [63:0] data_in,
  output logic [63:0] data_out,
  output logic        done,
  output logic [1:0]  stage
);
  localparam int STEPS = N_ROUNDS / ROUNDS_PER_CLK;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic             loading, tri_mode, accept, last_rnd, fin;
  logic [IDX_W-1:0] step;

  tdes_iter_seq #(.STEPS(STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (start),
    .triple   (triple),
    .stage    (stage),
    .loading  (loading),
    .step     (step),
    .tri_mode (tri_mode),
    .accept   (accept),
    .last_rnd (last_rnd),
    .fin      (fin)
  );

  logic [63:0] k0_q, k0_n, k1_q, k1_n, k2_q, k2_n;
  logic        enc_q, enc_n;
  logic [63:0] blk_q, blk_n;
  logic [63:0] lr_q, lr_n;
  logic [55:0] cd_q, cd_n;
  logic [63:0] dout_q, dout_n;
  logic        done_q, done_n;

  // Key and direction of the running stage.
  logic [63:0] stage_key;
  logic        dec_now;
  always_comb begin
    case (stage)
      2'd2:    stage_key = k1_q;
      2'd3:    stage_key = enc_q ? k2_q : k0_q;
      default: stage_key = (enc_q || !tri_mode) ? k0_q : k2_q;
    endcase
    dec_now = !enc_q ^ (stage == 2'd2);
  end

  // Chained round units, one per round folded into a clock.
  logic [ROUNDS_PER_CLK:0][63:0] chain;
  assign chain[0] = lr_q;

  for (genvar g = 0; g < ROUNDS_PER_CLK; g++) begin : g_rnd
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] key_idx;
    logic [47:0]      subkey;
    assign rnd_idx = IDX_W'(int'(step) * ROUNDS_PER_CLK + g);
    assign key_idx = dec_now ? (IDX_W'(N_ROUNDS - 1) - rnd_idx) : rnd_idx;

    tdes_iter_subkey u_key (
      .cd     (cd_q),
      .idx    (key_idx),
      .subkey (subkey)
    );

    tdes_iter_round u_round (
      .lr_in  (chain[g]),
      .subkey (subkey),
      .lr_out (chain[g+1])
    );
  end

  logic [63:0] stage_res;
  assign stage_res = perm_fp({chain[ROUNDS_PER_CLK][31:0], chain[ROUNDS_PER_CLK][63:32]});

  always_comb begin
    k0_n   = k0_q;
    k1_n   = k1_q;
    k2_n   = k2_q;
    enc_n  = enc_q;
    blk_n  = blk_q;
    lr_n   = lr_q;
    cd_n   = cd_q;
    dout_n = dout_q;
    done_n = fin;
    if (accept) begin
      k0_n  = key0;
      k1_n  = key1;
      k2_n  = key2;
      enc_n = encrypt;
      blk_n = data_in;
    end
    if (loading) begin
      lr_n = perm_ip(blk_q);
      cd_n = perm_pc1(stage_key);
    end else if (stage != 2'd0) begin
      lr_n = chain[ROUNDS_PER_CLK];
      if (last_rnd && !fin) blk_n = stage_res;
    end
    if (fin) dout_n = stage_res;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      k0_q   <= '0;
      k1_q   <= '0;
      k2_q   <= '0;
      enc_q  <= 1'b0;
      blk_q  <= '0;
      lr_q   <= '0;
      cd_q   <= '0;
      dout_q <= '0;
      done_q <= 1'b0;
    end else begin
      k0_q   <= k0_n;
      k1_q   <= k1_n;
      k2_q   <= k2_n;
      enc_q  <= enc_n;
      blk_q  <= blk_n;
      lr_q   <= lr_n;
      cd_q   <= cd_n;
      dout_q <= dout_n;
      done_q <= done_n;
    end
  end

  assign data_out = dout_q;
  assign done     = done_q;
endmodule

// File: rtl/tdes_iter_core_chk.sv
module tdes_iter_core_chk #(
  parameter int ROUNDS_PER_CLK = 1
)(
  input logic        clk,
  input logic        rst_ok,
  input logic        start,
  input logic        triple,
  input logic [1:0]  stage,
  input logic        done,
  input logic [63:0] data_out
);
  localparam int PER = 1 + 16 / ROUNDS_PER_CLK;

  logic       run_q;
  logic       tri_l;
  logic [7:0] el_q;
  logic [7:0] lat;

  assign lat = tri_l ? 8'(3 * PER) : 8'(PER);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      run_q <= 1'b0;
      tri_l <= 1'b0;
      el_q  <= '0;
    end else if (start && stage == 2'd0) begin
      run_q <= 1'b1;
      tri_l <= triple;
      el_q  <= '0;
    end else if (run_q) begin
      el_q <= el_q + 8'd1;
      if (done) run_q <= 1'b0;
    end
  end

  AST_ACCEPT_STAGE1: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && stage == 2'd0) |=> (stage == 2'd1));                    // R5

  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (stage != 2'd0) |=> (stage == 2'd0 || stage == $past(stage) ||
                          stage == $past(stage) + 2'd1));              // R5

  AST_SINGLE_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_ok)
    (run_q && !tri_l) |-> (stage <= 2'd1));                           // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (stage == 2'd0));                                         // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);                                                   // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !done |-> $stable(data_out));                                      // R6

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (run_q && el_q == lat));                                  // R4

  AST_BUSY_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && stage != 2'd0 && !done) |=> (stage != 2'd1 || $past(stage) == 2'd1)); // R7
endmodule

bind tdes_iter_core tdes_iter_core_chk #(.ROUNDS_PER_CLK(ROUNDS_PER_CLK)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_s),
  .start    (start),
  .triple   (triple),
  .stage    (stage),
  .done     (done),
  .data_out (data_out)
);

// File: tb/tb_tdes_iter_core.sv
`timescale 1ns/1ps
module tb_tdes_iter_core;
  localparam int RPC = 1;
  localparam int PER = 1 + 16 / RPC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, encrypt, triple;
  logic [63:0] key0, key1, key2, data_in;
  logic [63:0] data_out;
  logic        done;
  logic [1:0]  stage;

  always #2.5 clk = ~clk;

  tdes_iter_core #(.ROUNDS_PER_CLK(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .encrypt(encrypt), .triple(triple),
    .key0(key0), .key1(key1), .key2(key2), .data_in(data_in),
    .data_out(data_out), .done(done), .stage(stage)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural timing model: elapsed cycles since the accepting edge.
  bit m_busy = 1'b0;
  bit m_done = 1'b0;
  int m_n = 0;
  int m_len = 0;
  bit cmp_en = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_n <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1'b1; m_n <= 0; m_len <= triple ? 3 * PER : PER;
        end
      end else begin
        if (m_n + 1 == m_len) begin m_busy <= 1'b0; m_done <= 1'b1; end
        m_n <= m_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      int es;
      es = m_busy ? (m_n / PER + 1) : 0;
      chk(int'(stage) == es, "R5 stage per cycle", 64'(stage), 64'(es));
      chk(done == m_done, "R4 done timing", 64'(done), 64'(m_done));
    end
  end

  task automatic wait_done(input int exp_len, input string tag, output logic [63:0] res);
    int w = 0;
    while (!done && w < 400) begin @(negedge clk); w++; end
    chk(w == exp_len, {tag, " R4 latency"}, 64'(w), 64'(exp_len));
    res = data_out;
  endtask

  task automatic run_op(input bit enc, input bit tri3, input logic [63:0] ka, input logic [63:0] kb,
                        input logic [63:0] kc, input logic [63:0] din, input string tag,
                        output logic [63:0] res);
    encrypt = enc; triple = tri3; key0 = ka; key1 = kb; key2 = kc; data_in = din; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(tri3 ? 3 * PER : PER, tag, res);
    @(negedge clk);
  endtask

  localparam logic [63:0] KA = 64'h133457799BBCDFF1;
  localparam logic [63:0] PA = 64'h0123456789ABCDEF;
  localparam logic [63:0] CA = 64'h85E813540F0AB405;
  localparam logic [63:0] KB = 64'h0E329232EA6D0D73;
  localparam logic [63:0] PB = 64'h8787878787878787;
  localparam logic [63:0] CB = 64'h0000000000000000;
  localparam logic [63:0] KX = 64'hA1B2C3D4E5F60718;
  localparam logic [63:0] KY = 64'h5566778899AABBCC;

  initial begin
    logic [63:0] r, e1, e2, e3, t, held;
    rst_n = 1'b0; start = 1'b0; encrypt = 1'b0; triple = 1'b0;
    key0 = '0; key1 = '0; key2 = '0; data_in = '0;
    repeat (3) @(negedge clk);
    chk(stage == 2'd0, "R9 reset stage", 64'(stage), 64'd0);
    chk(done == 1'b0, "R9 reset done", 64'(done), 64'd0);
    chk(data_out == 64'd0, "R9 reset data_out", data_out, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;

    run_op(1, 0, KA, '0, '0, PA, "R1 kat A enc", r);
    chk(r == CA, "R1 kat A enc", r, CA);
    run_op(0, 0, KA, '0, '0, CA, "R2 kat A dec", r);
    chk(r == PA, "R2 kat A dec", r, PA);
    run_op(1, 0, KB, '0, '0, PB, "R1 kat B enc", r);
    chk(r == CB, "R1 kat B enc", r, CB);
    run_op(0, 0, KB, '0, '0, CB, "R2 kat B dec", r);
    chk(r == PB, "R2 kat B dec", r, PB);

    run_op(1, 1, KA, KA, KA, PA, "R3 equal keys", r);
    chk(r == CA, "R3 triple equal keys", r, CA);
    run_op(1, 1, KA, KX, KX, PA, "R3 k1=k2", r);
    chk(r == CA, "R3 triple middle pair cancels", r, CA);

    run_op(1, 0, KA, '0, '0, PB, "R3 compose 1", e1);
    run_op(0, 0, KX, '0, '0, e1, "R3 compose 2", e2);
    run_op(1, 0, KY, '0, '0, e2, "R3 compose 3", e3);
    run_op(1, 1, KA, KX, KY, PB, "R3 triple enc", t);
    chk(t == e3, "R3 triple enc key order", t, e3);
    run_op(0, 1, KA, KX, KY, t, "R3 triple dec", r);
    chk(r == PB, "R3 triple dec reverses", r, PB);

    // R7: start pulse while busy
    encrypt = 1; triple = 0; key0 = KA; data_in = PA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    data_in = PB; triple = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; triple = 1'b0;
    wait_done(PER - 5, "R7 busy start", r);
    chk(r == CA, "R7 busy start ignored", r, CA);
    @(negedge clk);

    // R8: inputs change after acceptance
    encrypt = 1; triple = 0; key0 = KB; data_in = PB; start = 1'b1;
    @(negedge clk);
    start = 1'b0; key0 = KX; data_in = PA; encrypt = 0;
    wait_done(PER, "R8 capture", r);
    chk(r == CB, "R8 operands captured", r, CB);
    held = r;

    // R6: result held, no further done
    repeat (12) @(negedge clk);
    chk(data_out == held, "R6 data_out held", data_out, held);
    chk(done == 1'b0, "R6 done single pulse", 64'(done), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 20000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule